// File: doc/BRIEF.md
# Raster Timing Generator with Frame Counter

This block produces the horizontal and vertical timing for a parallel RGB display. It is clocked by the pixel clock. Each line and each frame runs through four phases: sync, back porch, active and front porch. The length of every phase comes from an input register value that holds the wanted count minus one. The block outputs sync strobes, a data-enable window and the pixel position inside the active area. It also keeps a 32-bit frame counter and reports which vertical phase the raster is in, so that software can tell whether the counter has already moved for the frame being shown.

There are three ways to run the block:

- **Continuous video mode.** Frames repeat for as long as the enable is high. The frame counter steps when vertical sync starts.
- **Interlaced video mode.** This is video mode with the raster split into fields. Each field carries the programmed line count, which is half the picture height. Only the first field of each pair raises the frame interrupt.
- **Command mode.** No timing runs until a trigger arrives. A trigger starts one transfer that begins at the back porch, skips vertical sync and emits no sync strobes. The frame counter steps when that back porch begins. The trigger is either a rising edge on a tearing-effect input or a one-cycle software strobe; a select input chooses which one.

All timing values and the mode are sampled only when a frame starts. To reset the block from software, first drop the enable and wait for the stop flag, then pulse the synchronous reset. That returns the raster to idle and clears the counter, the field and the pending interrupt.

Top module: `disp_timing_gen`

## Requirements
- R1: After `rst_n` is released, `stopped`=1, `frame_cnt`=0, `vphase`=0, and `hsync`, `vsync`, `de`, `cmd_busy`, `field` and `irq_pend` are all 0.
- R2: A line lasts `hsw+hbp+hact+hfp+4` cycles, in the phase order sync, back porch, active, front porch. In video mode `hsync` is high for the first `hsw+1` cycles of every line.
- R3: A video frame lasts `vsw+vbp+vact+vfp+4` lines, starting with `vsync` high for `vsw+1` lines. `de` is high for `(hact+1)*(vact+1)` cycles per frame. During `de`, `px` runs from 0 to `hact` and `py` runs from 0 to `vact`.
- R4: In video mode `frame_cnt` increments by one, modulo 2^32, in the same cycle that `vsync` rises.
- R5: `vphase` encodes the vertical phase as 0 = sync, 1 = back porch, 2 = active and 3 = front porch. It reads 0 when idle. In video mode it becomes 1 exactly `(vsw+1)` lines after the frame starts.
- R6: In command mode (`cmd_mode`=1) nothing runs without a trigger. A triggered transfer lasts `(vbp+vfp+vact+3)` lines with `cmd_busy`=1 and with `hsync` and `vsync` held at 0. In its first cycle `vphase`=1 and `frame_cnt` has already incremented.
- R7: With `trig_hw`=1 only a rising edge of `te` starts a transfer. With `trig_hw`=0 only `sw_trig` starts one. A trigger that arrives while a transfer is running is dropped and is not queued.
- R8: With `interlace`=1, `field` is 0 in the first field after start and toggles at each following field. The active-end interrupt is suppressed when `field`=1.
- R9: `irq_pend` is set when the last active line of a frame or field ends. It stays set until `irq_clr` is pulsed; a set in the same cycle wins over the clear.
- R10: Changes to timing values made during a frame take effect only from the next frame start.
- R11: When `en` drops, the current frame still completes. `stopped` rises at its end and no new frame begins.
- R12: `srst` returns the block to idle in one cycle and clears `frame_cnt`, `field` and `irq_pend`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| srst | input | 1 | Synchronous software reset strobe |
| en | input | 1 | Video enable |
| cmd_mode | input | 1 | 1 = command mode (triggered transfers) |
| interlace | input | 1 | 1 = interlaced fields |
| trig_hw | input | 1 | Trigger select: 1 = `te` edge, 0 = `sw_trig` |
| te | input | 1 | Tearing-effect input (rising edge used) |
| sw_trig | input | 1 | Software trigger strobe |
| irq_clr | input | 1 | Clears the pending interrupt |
| hsw | input | CW | Horizontal sync width minus one |
| hbp | input | CW | Horizontal back porch minus one |
| hact | input | CW | Active pixels per line minus one |
| hfp | input | CW | Horizontal front porch minus one |
| vsw | input | CW | Vertical sync width minus one, in lines |
| vbp | input | CW | Vertical back porch minus one, in lines |
| vact | input | CW | Active lines (per field) minus one |
| vfp | input | CW | Vertical front porch minus one, in lines |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| de | output | 1 | Data enable |
| px | output | CW | Pixel column in the active area |
| py | output | CW | Line in the active area |
| frame_cnt | output | FW | Frame counter |
| vphase | output | 2 | Vertical phase code |
| cmd_busy | output | 1 | Command-mode transfer running |
| field | output | 1 | Current field of an interlaced raster |
| stopped | output | 1 | Raster idle |
| irq_pend | output | 1 | Sticky frame interrupt |

## Verification
The hardest case to reach is the mid-frame register change. The new values must be ignored until the frame ends and then used for the whole of the next frame. The stimulus gets there by swapping in a much larger timing set a few cycles after `vsync` rises. It then measures the remaining frame against the old length and the following frame against the new one. The suppressed interrupt in the second field is reached the same way: the stimulus clears the pending bit between fields and samples it after each field's active area has ended. Command transfers get strobes during the transfer and from the unselected trigger source, to show that neither one starts or queues a frame.

// File: rtl/disp_timing_gen.sv
module disp_timing_gen #(
  parameter int CW = 12,
  parameter int FW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          srst,
  input  logic          en,
  input  logic          cmd_mode,
  input  logic          interlace,
  input  logic          trig_hw,
  input  logic          te,
  input  logic          sw_trig,
  input  logic          irq_clr,
  input  logic [CW-1:0] hsw,
  input  logic [CW-1:0] hbp,
  input  logic [CW-1:0] hact,
  input  logic [CW-1:0] hfp,
  input  logic [CW-1:0] vsw,
  input  logic [CW-1:0] vbp,
  input  logic [CW-1:0] vact,
  input  logic [CW-1:0] vfp,
  output logic          hsync,
  output logic          vsync,
  output logic          de,
  output logic [CW-1:0] px,
  output logic [CW-1:0] py,
  output logic [FW-1:0] frame_cnt,
  output logic [1:0]    vphase,
  output logic          cmd_busy,
  output logic          field,
  output logic          stopped,
  output logic          irq_pend
);
  localparam logic [1:0] PH_S = 2'd0, PH_B = 2'd1, PH_A = 2'd2, PH_F = 2'd3;

  logic          run, cmd_q, ilace_q, te_q;
  logic [CW-1:0] s_hsw, s_hbp, s_hact, s_hfp, s_vsw, s_vbp, s_vact, s_vfp;
  logic [1:0]    hph, vph;
  logic [CW-1:0] hcnt, vcnt, hlen, vlen;

  always_comb begin
    case (hph)
      PH_S:    hlen = s_hsw;
      PH_B:    hlen = s_hbp;
      PH_A:    hlen = s_hact;
      default: hlen = s_hfp;
    endcase
    case (vph)
      PH_S:    vlen = s_vsw;
      PH_B:    vlen = s_vbp;
      PH_A:    vlen = s_vact;
      default: vlen = s_vfp;
    endcase
  end

  wire h_last     = hcnt == hlen;
  wire v_last     = vcnt == vlen;
  wire line_end   = run && h_last && hph == PH_F;
  wire frame_end  = line_end && v_last && vph == PH_F;
  wire act_done   = line_end && v_last && vph == PH_A;
  wire te_rise    = te && !te_q;
  wire trig       = trig_hw ? te_rise : sw_trig;
  wire start_idle = !run && en && (cmd_mode ? trig : 1'b1);
  wire restart    = frame_end && en && !cmd_mode && !cmd_q;
  wire new_frame  = start_idle || restart;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run <= 1'b0; cmd_q <= 1'b0; ilace_q <= 1'b0; te_q <= 1'b0;
      s_hsw <= '0; s_hbp <= '0; s_hact <= '0; s_hfp <= '0;
      s_vsw <= '0; s_vbp <= '0; s_vact <= '0; s_vfp <= '0;
      hph <= PH_S; vph <= PH_S; hcnt <= '0; vcnt <= '0;
      frame_cnt <= '0; field <= 1'b0; irq_pend <= 1'b0;
    end else begin
      te_q <= te;
      if (srst) begin
        run <= 1'b0; hph <= PH_S; vph <= PH_S; hcnt <= '0; vcnt <= '0;
        frame_cnt <= '0; field <= 1'b0; irq_pend <= 1'b0;
      end else begin
        if (new_frame) begin
          run     <= 1'b1;
          cmd_q   <= cmd_mode;
          ilace_q <= interlace;
          s_hsw <= hsw; s_hbp <= hbp; s_hact <= hact; s_hfp <= hfp;
          s_vsw <= vsw; s_vbp <= vbp; s_vact <= vact; s_vfp <= vfp;
          hph  <= PH_S; hcnt <= '0; vcnt <= '0;
          vph  <= cmd_mode ? PH_B : PH_S;
          frame_cnt <= frame_cnt + FW'(1);
          field <= (restart && interlace && ilace_q) ? ~field : 1'b0;
        end else if (run) begin
          if (frame_end) begin
            run <= 1'b0; hph <= PH_S; vph <= PH_S;
            hcnt <= '0; vcnt <= '0; field <= 1'b0;
          end else if (h_last) begin
            hcnt <= '0;
            hph  <= hph + 2'd1;
            if (hph == PH_F) begin
              if (v_last) begin
                vcnt <= '0;
                vph  <= vph + 2'd1;
              end else begin
                vcnt <= vcnt + CW'(1);
              end
            end
          end else begin
            hcnt <= hcnt + CW'(1);
          end
        end
        if (act_done && !(ilace_q && field)) irq_pend <= 1'b1;
        else if (irq_clr)                    irq_pend <= 1'b0;
      end
    end
  end

  assign hsync    = run && !cmd_q && hph == PH_S;
  assign vsync    = run && !cmd_q && vph == PH_S;
  assign de       = run && hph == PH_A && vph == PH_A;
  assign px       = de ? hcnt : '0;
  assign py       = de ? vcnt : '0;
  assign vphase   = run ? vph : PH_S;
  assign cmd_busy = run && cmd_q;
  assign stopped  = !run;
endmodule

// File: rtl/disp_timing_gen_chk.sv
module disp_timing_gen_chk #(
  parameter int FW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          srst,
  input logic          irq_clr,
  input logic          hsync,
  input logic          vsync,
  input logic          de,
  input logic          cmd_busy,
  input logic          stopped,
  input logic [FW-1:0] frame_cnt,
  input logic          irq_pend,
  input logic [1:0]    vphase
);
  assert_blank_sync_R2: assert property (@(posedge clk) disable iff (!rst_n)
    de |-> !hsync && !vsync);

  assert_cnt_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(frame_cnt) |-> (frame_cnt == $past(frame_cnt) + FW'(1)) || (frame_cnt == '0));

  assert_vs_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vsync) |-> frame_cnt == $past(frame_cnt) + FW'(1));

  assert_de_phase_R5: assert property (@(posedge clk) disable iff (!rst_n)
    de |-> vphase == 2'd2);

  assert_cmd_nosync_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_busy |-> !hsync && !vsync);

  assert_irq_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pend && !irq_clr && !srst |=> irq_pend);

  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    stopped |-> !de && !hsync && !vsync && !cmd_busy && vphase == 2'd0);
endmodule

bind disp_timing_gen disp_timing_gen_chk #(.FW(FW)) chk_i (
  .clk(clk), .rst_n(rst_n), .srst(srst), .irq_clr(irq_clr),
  .hsync(hsync), .vsync(vsync), .de(de), .cmd_busy(cmd_busy),
  .stopped(stopped), .frame_cnt(frame_cnt), .irq_pend(irq_pend),
  .vphase(vphase)
);

// File: tb/disp_timing_gen_tb_top.sv
`timescale 1ns/1ps
module disp_timing_gen_tb_top;
  localparam int CW = 12;
  localparam int FW = 32;
  localparam int NV = 3;
  // hsw hbp hact hfp vsw vbp vact vfp | period de_cycles hsync_cycles
  localparam int TBL [NV][11] = '{
    '{0, 1, 3, 0, 0, 0, 2, 1,  56, 12,  7},
    '{1, 0, 4, 2, 1, 1, 1, 0,  77, 10, 14},
    '{2, 2, 7, 1, 0, 2, 3, 0, 144, 32, 27}
  };

  logic clk = 0, rst_n = 0, srst = 0, en = 0, cmd_mode = 0, interlace = 0;
  logic trig_hw = 0, te = 0, sw_trig = 0, irq_clr = 0;
  logic [CW-1:0] hsw = '0, hbp = '0, hact = '0, hfp = '0;
  logic [CW-1:0] vsw = '0, vbp = '0, vact = '0, vfp = '0;
  logic hsync, vsync, de, cmd_busy, field, stopped, irq_pend;
  logic [CW-1:0] px, py;
  logic [FW-1:0] frame_cnt;
  logic [1:0] vphase;
  int checks = 0, errors = 0;

  disp_timing_gen #(.CW(CW), .FW(FW)) dut_i (
    .clk(clk), .rst_n(rst_n), .srst(srst), .en(en), .cmd_mode(cmd_mode),
    .interlace(interlace), .trig_hw(trig_hw), .te(te), .sw_trig(sw_trig),
    .irq_clr(irq_clr), .hsw(hsw), .hbp(hbp), .hact(hact), .hfp(hfp),
    .vsw(vsw), .vbp(vbp), .vact(vact), .vfp(vfp), .hsync(hsync),
    .vsync(vsync), .de(de), .px(px), .py(py), .frame_cnt(frame_cnt),
    .vphase(vphase), .cmd_busy(cmd_busy), .field(field),
    .stopped(stopped), .irq_pend(irq_pend)
  );

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic set_cfg(input int i);
    hsw = CW'(TBL[i][0]); hbp = CW'(TBL[i][1]); hact = CW'(TBL[i][2]); hfp = CW'(TBL[i][3]);
    vsw = CW'(TBL[i][4]); vbp = CW'(TBL[i][5]); vact = CW'(TBL[i][6]); vfp = CW'(TBL[i][7]);
  endtask

  task automatic wait_rise();
    bit pv;
    pv = vsync;
    for (int k = 0; k < 2000; k++) begin
      @(negedge clk);
      if (vsync && !pv) return;
      pv = vsync;
    end
    chk(1'b0, "R3 vsync rise timeout", 0, 1);
  endtask

  task automatic stop_and_reset();
    en = 0;
    for (int k = 0; k < 1000 && !stopped; k++) @(negedge clk);
    srst = 1;
    @(negedge clk);
    srst = 0;
  endtask

  task automatic measure(input int chg_at, input int chg_idx,
                         output int per, output int den, output int hsn,
                         output int bpat, output int pxm, output int pym,
                         output longint f0);
    bit pv;
    per = 0; den = 0; hsn = 0; bpat = -1; pxm = 0; pym = 0;
    f0 = longint'(frame_cnt);
    do begin
      if (per == chg_at) set_cfg(chg_idx);
      if (vphase == 2'd1 && bpat < 0) bpat = per;
      den += int'(de);
      hsn += int'(hsync);
      if (de && int'(px) > pxm) pxm = int'(px);
      if (de && int'(py) > pym) pym = int'(py);
      pv = vsync;
      per++;
      @(negedge clk);
    end while (!(vsync && !pv) && per < 5000);
  endtask

  initial begin
    #(2_000_000);
    checks++; errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int per, den, hsn, bpat, pxm, pym, k;
    longint f0, fc;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(stopped == 1'b1, "R1 stopped", stopped, 1);
    chk(frame_cnt == '0, "R1 frame_cnt", frame_cnt, 0);
    chk({hsync, vsync, de, cmd_busy, field, irq_pend} == 6'b0, "R1 outputs", {hsync, vsync, de, cmd_busy, field, irq_pend}, 0);
    chk(vphase == 2'd0, "R1 vphase", vphase, 0);

    for (int i = 0; i < NV; i++) begin
      set_cfg(i);
      en = 1;
      wait_rise();
      measure(-1, 0, per, den, hsn, bpat, pxm, pym, f0);
      chk(per == TBL[i][8], "R3 frame period", per, TBL[i][8]);
      chk(den == TBL[i][9], "R3 de cycles", den, TBL[i][9]);
      chk(hsn == TBL[i][10], "R2 hsync cycles", hsn, TBL[i][10]);
      chk(pxm == TBL[i][2], "R3 px max", pxm, TBL[i][2]);
      chk(pym == TBL[i][6], "R3 py max", pym, TBL[i][6]);
      k = (TBL[i][4] + 1) * (TBL[i][0] + TBL[i][1] + TBL[i][2] + TBL[i][3] + 4);
      chk(bpat == k, "R5 back porch entry", bpat, k);
      chk(longint'(frame_cnt) == f0 + 1, "R4 count at vsync rise", frame_cnt, f0 + 1);
      chk(vphase == 2'd0, "R5 sync code", vphase, 0);
      chk(irq_pend == 1'b1, "R9 pending after frame", irq_pend, 1);
      irq_clr = 1;
      @(negedge clk);
      irq_clr = 0;
      chk(irq_pend == 1'b0, "R9 cleared", irq_pend, 0);
      stop_and_reset();
      chk(frame_cnt == '0, "R12 count cleared", frame_cnt, 0);
      chk(irq_pend == 1'b0, "R12 pending cleared", irq_pend, 0);
    end

    // R10: mid-frame change waits for the next frame
    set_cfg(0);
    en = 1;
    wait_rise();
    measure(3, 2, per, den, hsn, bpat, pxm, pym, f0);
    chk(per == 56, "R10 current frame kept", per, 56);
    chk(den == 12, "R10 current de kept", den, 12);
    measure(-1, 0, per, den, hsn, bpat, pxm, pym, f0);
    chk(per == 144, "R10 next frame period", per, 144);
    chk(den == 32, "R10 next frame de", den, 32);
    stop_and_reset();

    // R11: dropping enable finishes the frame
    set_cfg(0);
    en = 1;
    wait_rise();
    en = 0;
    k = 0;
    do begin @(negedge clk); k++; end while (!stopped && k < 1000);
    chk(k == 56, "R11 stop after frame", k, 56);
    fc = longint'(frame_cnt);
    repeat (20) @(negedge clk);
    chk(stopped && longint'(frame_cnt) == fc, "R11 no new frame", frame_cnt, fc);

    // R12: reset mid-frame
    en = 1;
    wait_rise();
    repeat (5) @(negedge clk);
    srst = 1;
    @(negedge clk);
    srst = 0;
    en = 0;
    chk(stopped == 1'b1, "R12 idle after srst", stopped, 1);
    chk(frame_cnt == '0, "R12 counter zero", frame_cnt, 0);
    @(negedge clk);

    // R8: interlaced fields
    set_cfg(0);
    interlace = 1;
    en = 1;
    wait_rise();
    chk(field == 1'b0, "R8 first field", field, 0);
    repeat (48) @(negedge clk);
    chk(irq_pend == 1'b1, "R8 irq field 0", irq_pend, 1);
    irq_clr = 1;
    @(negedge clk);
    irq_clr = 0;
    wait_rise();
    chk(field == 1'b1, "R8 second field", field, 1);
    repeat (48) @(negedge clk);
    chk(irq_pend == 1'b0, "R8 irq suppressed", irq_pend, 0);
    wait_rise();
    chk(field == 1'b0, "R8 field toggles back", field, 0);
    repeat (48) @(negedge clk);
    chk(irq_pend == 1'b1, "R8 irq next frame", irq_pend, 1);
    interlace = 0;
    stop_and_reset();

    // R6/R7: command mode
    set_cfg(0);
    cmd_mode = 1;
    trig_hw = 0;
    en = 1;
    repeat (100) @(negedge clk);
    chk(stopped && frame_cnt == '0, "R6 no trigger no transfer", frame_cnt, 0);
    te = 1;
    repeat (3) @(negedge clk);
    te = 0;
    repeat (3) @(negedge clk);
    chk(stopped && frame_cnt == '0, "R7 te ignored when sw selected", frame_cnt, 0);
    sw_trig = 1;
    @(negedge clk);
    sw_trig = 0;
    chk(cmd_busy == 1'b1, "R6 busy after trigger", cmd_busy, 1);
    chk(vphase == 2'd1, "R6 starts in back porch", vphase, 1);
    chk(frame_cnt == FW'(1), "R6 count at back porch", frame_cnt, 1);
    k = 0;
    per = 0;
    while (cmd_busy && k < 1000) begin
      if (hsync || vsync) per = 1;
      sw_trig = (k == 10);
      k++;
      @(negedge clk);
    end
    sw_trig = 0;
    chk(k == 48, "R6 transfer length", k, 48);
    chk(per == 0, "R6 no sync strobes", per, 0);
    repeat (10) @(negedge clk);
    chk(stopped && frame_cnt == FW'(1), "R7 busy trigger dropped", frame_cnt, 1);
    trig_hw = 1;
    sw_trig = 1;
    @(negedge clk);
    sw_trig = 0;
    repeat (3) @(negedge clk);
    chk(stopped == 1'b1, "R7 sw ignored when te selected", stopped, 1);
    te = 1;
    @(negedge clk);
    te = 0;
    chk(cmd_busy == 1'b1, "R7 te edge starts", cmd_busy, 1);
    chk(frame_cnt == FW'(2), "R7 count after te", frame_cnt, 2);
    for (int j = 0; j < 1000 && cmd_busy; j++) @(negedge clk);
    en = 0;
    cmd_mode = 0;
    @(negedge clk);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule